// File: doc/BRIEF.md
# Bi-Endian Byte-Lane RAM Slave

This block is a small synchronous RAM attached to a 32-bit pipelined system bus with separate read and write data paths. A master starts a transfer in an address cycle. The block registers that request, and the memory access happens in the data cycle that follows. Each transfer moves one byte, one halfword or one word. The block copies only the active byte lanes of the write bus into storage. On a read it drives only the active lanes and forces the others to zero.

A static input, `cfg_big_endian`, selects how an address offset maps to byte lanes. With the input low, offset 0 sits in the least significant lane. With the input high, offset 0 sits in the most significant lane. The parameter `WAIT_STATES` stretches every aligned transfer by the same number of cycles, from 0 to 3. The block rejects a transfer that is not aligned to its size, or that asks for more than 32 bits. It answers such a transfer with a two-cycle error and leaves storage untouched.

Top module: `eram_slave`

## Requirements
- R1: After reset, `bus_ready_out` is 1, `bus_resp_err` is 0 and `bus_rdata` is 0.
- R2: A cycle is taken as an address phase only when `bus_sel` is 1, `bus_trans` is 2'b10 or 2'b11, and `bus_ready_in` is 1. Any other cycle starts no access, leaves storage unchanged and keeps `bus_ready_out` at 1.
- R3: Size encoding is 0 for a byte, 1 for a halfword and 2 for a word. With `cfg_big_endian`=0, a byte at offset k uses bits [8k+7:8k]. A halfword at offset 0 uses [15:0], and at offset 2 it uses [31:16].
- R4: With `cfg_big_endian`=1, a byte at offset k uses bits [31-8k:24-8k]. A halfword at offset 0 uses [31:16], and at offset 2 it uses [15:0].
- R5: A narrow write changes only the storage bytes of its active lanes. The other lanes of `bus_wdata` are ignored.
- R6: A read drives the stored bytes on its active lanes and zero on every other lane.
- R7: An aligned transfer holds `bus_ready_out` low for exactly `WAIT_STATES` data-phase cycles, then raises it with `bus_resp_err`=0. Read data is valid in that final cycle.
- R8: Write data is sampled only in the data-phase cycle where `bus_ready_out` is 1. Values on `bus_wdata` during wait cycles have no effect.
- R9: A halfword at an odd address, or a word whose address bits [1:0] are not 00, gets an error: one cycle with `bus_resp_err`=1 and `bus_ready_out`=0, then one cycle with both at 1. Storage is not modified.
- R10: A size code above 2 gets the same two-cycle error as R9.
- R11: During an error response, `bus_rdata` is 0.
- R12: A new address phase presented during the last cycle of a data phase is accepted, so back-to-back transfers complete in order without an idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_big_endian | input | 1 | Static lane-order select (1 = most significant lane first) |
| bus_sel | input | 1 | Slave select for the current address phase |
| bus_trans | input | 2 | Transfer type; bit 1 set marks an active transfer |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 3 | Transfer size code (0 byte, 1 halfword, 2 word) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data bus |
| bus_ready_in | input | 1 | Bus-wide ready; 1 ends the current data phase |
| bus_rdata | output | 32 | Read data bus |
| bus_ready_out | output | 1 | This slave's ready |
| bus_resp_err | output | 1 | 1 = error response |

## Verification
The hardest situation to reach is a data phase and a new address phase sharing one cycle. The test for it keeps the second request on the bus through all the wait states of the first, so the block accepts it exactly on the completing edge. The wait cycles are also used to show that write data is sampled late: during them the bench drives the complement of the intended data, and switches to the real value only once ready is seen high. Byte lanes are exercised by writing in one lane order and reading back in the other, against a lane-indexed model.

// File: rtl/eram_pkg.sv
package eram_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;

  // Size and alignment legality
  function automatic logic size_ok(input logic [2:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: size_ok = 1'b1;
      SZ_HALF: size_ok = ~off[0];
      SZ_WORD: size_ok = (off == 2'b00);
      default: size_ok = 1'b0;
    endcase
  endfunction

  // Active lanes: little-endian pattern, mirrored for the big-endian order
  function automatic logic [LANES-1:0] lane_enables(input logic [2:0] sz,
                                                    input logic [1:0] off,
                                                    input logic       big);
    logic [LANES-1:0] m;
    case (sz)
      SZ_BYTE: m = 4'b0001 << off;
      SZ_HALF: m = off[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    lane_enables = big ? {m[0], m[1], m[2], m[3]} : m;
  endfunction

  function automatic logic [DATA_W-1:0] lanes_to_bits(input logic [LANES-1:0] m);
    for (int i = 0; i < LANES; i++) lanes_to_bits[8*i +: 8] = {8{m[i]}};
  endfunction
endpackage

// File: rtl/eram_addr_stage.sv
module eram_addr_stage
  import eram_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        trans,
  input  logic              write,
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ready_in,
  output logic              ph_valid,
  output logic              ph_write,
  output logic [2:0]        ph_size,
  output logic [1:0]        ph_off,
  output logic [WORD_W-1:0] ph_word,
  output logic              ph_bad
);
  logic req;
  assign req = sel && (trans == 2'b10 || trans == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_valid <= 1'b0;
      ph_write <= 1'b0;
      ph_size  <= SZ_BYTE;
      ph_off   <= '0;
      ph_word  <= '0;
      ph_bad   <= 1'b0;
    end else if (ready_in) begin
      ph_valid <= req;
      ph_write <= write;
      ph_size  <= size;
      ph_off   <= addr[1:0];
      ph_word  <= addr[ADDR_W-1:2];
      ph_bad   <= req && !size_ok(size, addr[1:0]);
    end
  end

  AST_BAD_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_bad |-> ph_valid); // R9
endmodule

// File: rtl/eram_resp_ctrl.sv
module eram_resp_ctrl #(
  parameter int WAIT_STATES = 2,
  localparam int CNT_W = $clog2(WAIT_STATES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_valid,
  input  logic ph_bad,
  input  logic ready_in,
  output logic ready_out,
  output logic resp_err,
  output logic done_ok
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (!ph_valid) begin
      ready_out = 1'b1;
      resp_err  = 1'b0;
    end else if (ph_bad) begin
      ready_out = (cnt != '0);
      resp_err  = 1'b1;
    end else begin
      ready_out = (cnt == CNT_W'(WAIT_STATES));
      resp_err  = 1'b0;
    end
  end

  assign done_ok = ph_valid && !ph_bad && ready_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (ready_in)              cnt <= '0;
    else if (ph_valid && !ready_out) cnt <= cnt + 1'b1;
  end

  AST_ERR_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_err && !ready_out && !ready_in) |=> (resp_err && ready_out)); // R9
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_valid |-> (ready_out && !resp_err)); // R2
  AST_WAIT_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ready_out && !ready_in) |=> ph_valid); // R7
endmodule

// File: rtl/eram_store.sv
module eram_store
  import eram_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bank [WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) bank[idx] <= wdata[8*g +: 8];
    end
    assign rword[8*g +: 8] = bank[idx];
  end

  AST_WRITE_LANE_COUNT: assert property (@(posedge clk)
    wr_en |-> ($countones(lane_en) == 1 || $countones(lane_en) == 2 ||
               $countones(lane_en) == 4)); // R5
endmodule

// File: rtl/eram_slave.sv
module eram_slave
  import eram_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WAIT_STATES = 2,
  localparam int WORD_W = ADDR_W - 2,
  localparam int WORDS  = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              bus_sel,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_ready_in,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready_out,
  output logic              bus_resp_err
);
  logic              ph_valid, ph_write, ph_bad, done_ok, wr_en;
  logic [2:0]        ph_size;
  logic [1:0]        ph_off;
  logic [WORD_W-1:0] ph_word;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] rword;

  eram_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .trans(bus_trans),
    .write(bus_write), .size(bus_size), .addr(bus_addr),
    .ready_in(bus_ready_in), .ph_valid(ph_valid), .ph_write(ph_write),
    .ph_size(ph_size), .ph_off(ph_off), .ph_word(ph_word), .ph_bad(ph_bad)
  );

  eram_resp_ctrl #(.WAIT_STATES(WAIT_STATES)) u_resp (
    .clk(clk), .rst_n(rst_n), .ph_valid(ph_valid), .ph_bad(ph_bad),
    .ready_in(bus_ready_in), .ready_out(bus_ready_out),
    .resp_err(bus_resp_err), .done_ok(done_ok)
  );

  assign lane_en = lane_enables(ph_size, ph_off, cfg_big_endian);
  assign wr_en   = done_ok && ph_write;

  eram_store #(.WORDS(WORDS)) u_store (
    .clk(clk), .wr_en(wr_en), .idx(ph_word), .lane_en(lane_en),
    .wdata(bus_wdata), .rword(rword)
  );

  assign bus_rdata = (done_ok && !ph_write) ? (rword & lanes_to_bits(lane_en)) : '0;

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_resp_err |-> (bus_rdata == '0)); // R11
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_resp_err |-> !wr_en); // R9
  AST_DATA_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata != '0) |-> (bus_ready_out && !bus_resp_err)); // R7
endmodule

// File: tb/eram_slave_test.sv
module eram_slave_test;
  localparam int WS = 2;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big = 1'b0;
  logic sel = 1'b0;
  logic [1:0] trans = 2'b00;
  logic wr = 1'b0;
  logic [2:0] size = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ready, err;

  always #2.5 clk = ~clk;

  eram_slave #(.ADDR_W(AW), .WAIT_STATES(WS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(big), .bus_sel(sel),
    .bus_trans(trans), .bus_write(wr), .bus_size(size), .bus_addr(addr),
    .bus_wdata(wdata), .bus_ready_in(ready), .bus_rdata(rdata),
    .bus_ready_out(ready), .bus_resp_err(err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] model [64][4];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Lane table written out per case (independent of the RTL)
  function automatic logic [3:0] exp_lanes(input logic b, input logic [2:0] sz, input logic [1:0] off);
    case ({b, sz[1:0], off})
      5'b0_00_00: return 4'b0001;  5'b0_00_01: return 4'b0010;
      5'b0_00_10: return 4'b0100;  5'b0_00_11: return 4'b1000;
      5'b0_01_00: return 4'b0011;  5'b0_01_10: return 4'b1100;
      5'b1_00_00: return 4'b1000;  5'b1_00_01: return 4'b0100;
      5'b1_00_10: return 4'b0010;  5'b1_00_11: return 4'b0001;
      5'b1_01_00: return 4'b1100;  5'b1_01_10: return 4'b0011;
      default:    return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] w, input logic [3:0] m);
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++) if (m[l]) v[8*l +: 8] = model[w][l];
    return v;
  endfunction

  task automatic model_write(input logic [5:0] w, input logic [3:0] m, input logic [31:0] d);
    for (int l = 0; l < 4; l++) if (m[l]) model[w][l] = d[8*l +: 8];
  endtask

  // One isolated transfer; complement of the data is driven during waits
  task automatic xfer(input logic w, input logic [2:0] sz, input logic [AW-1:0] a,
                      input logic [31:0] d, output logic [31:0] rd,
                      output logic rsp, output int waits, output bit err_first);
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; wr = w; size = sz; addr = a;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; trans = 2'b00;
    wdata = ~d; waits = 0; err_first = 1'b1;
    while (!ready) begin
      waits++;
      if (!err) err_first = 1'b0;
      @(negedge clk);
    end
    wdata = d;
    #0.5;
    rd = rdata; rsp = err;
    @(posedge clk);
  endtask

  task automatic good_xfer(input string tag, input logic w, input logic [2:0] sz,
                           input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic rsp; int waits; bit ef;
    logic [3:0] m = exp_lanes(big, sz, a[1:0]);
    xfer(w, sz, a, d, rd, rsp, waits, ef);
    chk(waits == WS, {tag, " R7 wait count"}, waits, WS);
    chk(rsp == 1'b0, {tag, " R7 okay"}, rsp, 0);
    if (w) model_write(a[AW-1:2], m, d);
    else chk(rd == exp_read(a[AW-1:2], m), tag, rd, exp_read(a[AW-1:2], m));
  endtask

  task automatic t_reset();
    #1;
    chk(ready == 1'b1 && err == 1'b0 && rdata == '0, "R1 reset outputs",
        {rdata[29:0], ready, err}, 32'h2);
  endtask

  task automatic t_little();
    big = 1'b0;
    good_xfer("R3 word wr", 1, 3'd2, 8'h10, 32'h44332211);
    for (int o = 0; o < 4; o++) good_xfer("R3 byte rd / R6", 0, 3'd0, AW'(8'h10 + o), 0);
    good_xfer("R3 half rd off0", 0, 3'd1, 8'h10, 0);
    good_xfer("R3 half rd off2", 0, 3'd1, 8'h12, 0);
  endtask

  task automatic t_big();
    big = 1'b1;
    for (int o = 0; o < 4; o++) good_xfer("R4 byte rd / R6", 0, 3'd0, AW'(8'h10 + o), 0);
    good_xfer("R4 half rd off0", 0, 3'd1, 8'h10, 0);
    good_xfer("R4 half rd off2", 0, 3'd1, 8'h12, 0);
    good_xfer("R4 byte wr off1", 1, 3'd0, 8'h11, 32'hA5A5A5A5);
    good_xfer("R4 word rd", 0, 3'd2, 8'h10, 0);
    chk(model[4][2] == 8'hA5, "R4 model lane", model[4][2], 8'hA5);
  endtask

  task automatic t_narrow_write();
    big = 1'b0;
    good_xfer("R5 word init", 1, 3'd2, 8'h20, 32'h00000000);
    good_xfer("R5 half wr", 1, 3'd1, 8'h22, 32'hDEADBEEF);
    good_xfer("R5 byte wr", 1, 3'd0, 8'h21, 32'hCAFEF00D);
    good_xfer("R5 word rd", 0, 3'd2, 8'h20, 0);
    good_xfer("R8 word wr", 1, 3'd2, 8'h24, 32'h13579BDF);
    good_xfer("R8 word rd", 0, 3'd2, 8'h24, 0);
  endtask

  task automatic bad_xfer(input string tag, input logic w, input logic [2:0] sz, input logic [AW-1:0] a);
    logic [31:0] rd; logic rsp; int waits; bit ef;
    xfer(w, sz, a, 32'hFFFFFFFF, rd, rsp, waits, ef);
    chk(waits == 1, {tag, " err wait"}, waits, 1);
    chk(ef && rsp, {tag, " err resp both cycles"}, {ef, rsp}, 2'b11);
    chk(rd == '0, "R11 err rdata zero", rd, 0);
  endtask

  task automatic t_errors();
    big = 1'b0;
    bad_xfer("R9 half odd wr", 1, 3'd1, 8'h21);
    bad_xfer("R9 word off2 wr", 1, 3'd2, 8'h22);
    bad_xfer("R9 word off1 rd", 0, 3'd2, 8'h25);
    bad_xfer("R10 size3 wr", 1, 3'd3, 8'h20);
    good_xfer("R9 mem unchanged", 0, 3'd2, 8'h20, 0);
  endtask

  task automatic t_idle();
    bit stay = 1'b1;
    @(negedge clk);
    sel = 1'b0; trans = 2'b10; wr = 1'b1; size = 3'd2; addr = 8'h24; wdata = 32'h0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (!ready) stay = 1'b0; end
    sel = 1'b1; trans = 2'b00;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (!ready) stay = 1'b0; end
    sel = 1'b0;
    chk(stay, "R2 ready held idle", stay, 1);
    good_xfer("R2 no write", 0, 3'd2, 8'h24, 0);
  endtask

  task automatic t_pipeline();
    int w1 = 0; int w2 = 0;
    logic [31:0] rd;
    big = 1'b1;
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; wr = 1'b1; size = 3'd2; addr = 8'h30;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; size = 3'd1; addr = 8'h32; wdata = 32'h89ABCDEF;
    while (!ready) begin w1++; @(negedge clk); end
    @(posedge clk);
    model_write(6'h0C, 4'b1111, 32'h89ABCDEF);
    @(negedge clk);
    sel = 1'b0; trans = 2'b00;
    while (!ready) begin w2++; @(negedge clk); end
    #0.5; rd = rdata;
    @(posedge clk);
    chk(w1 == WS && w2 == WS, "R12 waits", {w1[15:0], w2[15:0]}, {16'(WS), 16'(WS)});
    chk(rd == 32'h0000CDEF, "R12 pipelined read", rd, 32'h0000CDEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_little();
    t_big();
    t_narrow_write();
    t_errors();
    t_idle();
    t_pipeline();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule